// File: doc/BRIEF.md
# PLL Divider Setup and Lock Sequencer

This block brings a chain of clock-multiplying chips to a new system clock. On a start pulse it takes a reference frequency and a target system frequency, both in kHz. It derives a feedback divider with a multi-cycle sequential divider, using a fixed pre-divider of 2 and a starting post-divider of 4. It then folds the feedback divider into nine bits by trading factors of two into the post-divider. From the result it builds a six-byte configuration word and asks the transport layer to broadcast it as a register write.

Once the write is acknowledged, the block reads back a register from each active chip, one chip at a time, beginning at chip 1. It waits for the PLL lock flag, and between failed attempts it waits for a programmable number of cycles. The number of attempts per chip is limited. When a chip reports lock, the block compares the two divider bytes that chip echoes back against the bytes that were written. The sequence ends with a single-cycle done pulse, or with a single-cycle error pulse at the first problem.

Top module: `pll_cfg_sequencer`

## Requirements
- R1: The feedback divider is floor(sys_khz_i * 8 / ref_khz_i), where 8 is the pre-divider 2 times the starting post-divider 4. A zero reference gives an all-ones quotient.
- R2: While the feedback divider exceeds 511 and the post-divider is still 16 or less, the post-divider doubles and the feedback divider halves.
- R3: If the post-divider ends above 16, err_o pulses and neither a write request nor a read request is issued.
- R4: wr_cfg_o holds byte k at bits [8k+7:8k]. Byte 0 is {2'b10, post[4:0], fb[8]}, which equals (2<<6)|(post<<1)|fb[8]. Byte 1 is fb[7:0]. Byte 2 is 0x21, byte 3 is 0x84, and bytes 4 and 5 are zero.
- R5: wr_req_o stays high with wr_cfg_o stable until the cycle in which wr_ack_i is seen. An acknowledgement with wr_ok_i low ends the sequence with err_o and no read. wr_req_o and rd_req_o are never high together.
- R6: After the write, chips 1 up to the active count latched at start are read strictly in increasing order. Each chip's first read request is present in the cycle right after the previous acknowledgement. A count of zero gives done_o right after the write acknowledgement.
- R7: A reply counts as locked only when rd_ok_i is high and rd_lock_i is high. Any other reply is followed by a fresh request for the same chip exactly POLL_GAP_CYC cycles after the acknowledgement is consumed. The MAX_POLLS-th unlocked reply for a chip gives err_o.
- R8: On a locked reply, rd_cfg_i (reply byte 0 in [7:0], byte 1 in [15:8]) must equal config bytes 0 and 1. Otherwise err_o pulses and no further chip is read.
- R9: done_o and err_o are single-cycle pulses and never occur together. Each appears exactly in the cycle where busy_o falls. A start_i during busy_o is ignored, and the inputs are sampled only at an accepted start.
- R10: rd_req_o stays high with rd_chip_o stable until rd_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| ref_khz_i | input | FREQ_W | Reference clock in kHz |
| sys_khz_i | input | FREQ_W | Target system clock in kHz |
| chip_cnt_i | input | CHIP_W | Number of active chips |
| wr_req_o | output | 1 | Broadcast register write request |
| wr_cfg_o | output | 48 | Six-byte configuration word |
| wr_ack_i | input | 1 | Write completed (one-cycle) |
| wr_ok_i | input | 1 | Write succeeded, qualified by wr_ack_i |
| rd_req_o | output | 1 | Register read request |
| rd_chip_o | output | CHIP_W | Chip being read (1-based) |
| rd_ack_i | input | 1 | Read reply valid (one-cycle) |
| rd_ok_i | input | 1 | Read transfer succeeded |
| rd_lock_i | input | 1 | Reply byte 2 bit 0: PLL locked |
| rd_cfg_i | input | 16 | Reply bytes 0 and 1 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished with success (pulse) |
| err_o | output | 1 | Sequence aborted (pulse) |

## Verification
A wrong quotient or a wrong normalisation step shows up in bytes 0 and 1 of wr_cfg_o at the first write request, about FREQ_W+5 cycles after start. The bench sweeps a grid of reference and system values against an arithmetic model to catch this. A fault in the poll counter or the gap timer shows up within one retry, either as a request cycle that differs from the expected POLL_GAP_CYC spacing or as an error pulse that comes early or late. A fault in the chip index or the compare shows up on the next acknowledgement, as a wrong rd_chip_o value, a missing abort, or a spurious done.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int unsigned PRE_DIV    = 2;
  localparam int unsigned POST_INIT  = 4;
  localparam int unsigned POST_LIMIT = 16;
  localparam int unsigned FB_LIMIT   = 511;
  localparam int unsigned PRE_SHIFT  = $clog2(PRE_DIV * POST_INIT);
  localparam logic [7:0]  CFG_BYTE2  = 8'h21;
  localparam logic [7:0]  CFG_BYTE3  = 8'h84;
  localparam int unsigned CFG_W      = 48;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIV, ST_NORM, ST_WRITE, ST_READ, ST_GAP
  } seq_state_e;
endpackage

// File: rtl/pll_udiv.sv
module pll_udiv #(
  parameter int unsigned NUM_W = 23,
  parameter int unsigned DEN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  // restoring division, one quotient bit per cycle, MSB first
  assign trial = {rem_q, q_q[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        q_q   <= num_i;
        rem_q <= '0;
        den_q <= den_i;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        q_q   <= {q_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = q_q;
endmodule

// File: rtl/pll_div_norm.sv
module pll_div_norm
  import pll_seq_pkg::*;
#(
  parameter int unsigned FB_W = 23
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [FB_W-1:0] fb_i,
  output logic            done_o,
  output logic            ok_o,
  output logic [8:0]      fb_o,
  output logic [4:0]      post_o
);
  logic [FB_W-1:0] fb_q;
  logic [5:0]      post_q;
  logic            run_q, done_q, ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_q   <= '0;
      post_q <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        fb_q   <= fb_i;
        post_q <= 6'(POST_INIT);
        run_q  <= 1'b1;
      end else if (run_q) begin
        if (post_q > 6'(POST_LIMIT)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          ok_q   <= 1'b0;
        end else if (fb_q > FB_W'(FB_LIMIT)) begin
          fb_q   <= fb_q >> 1;
          post_q <= post_q << 1;
        end else begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          ok_q   <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign ok_o   = ok_q;
  assign fb_o   = fb_q[8:0];
  assign post_o = post_q[4:0];
endmodule

// File: rtl/pll_gap_timer.sv
module pll_gap_timer #(
  parameter int unsigned GAP_CYC = 8000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expire_o
);
  localparam int unsigned CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= CW'(GAP_CYC - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/pll_cfg_sequencer.sv
module pll_cfg_sequencer
  import pll_seq_pkg::*;
#(
  parameter int unsigned FREQ_W       = 20,
  parameter int unsigned CHIP_W       = 8,
  parameter int unsigned MAX_POLLS    = 25,
  parameter int unsigned POLL_GAP_CYC = 8000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] ref_khz_i,
  input  logic [FREQ_W-1:0] sys_khz_i,
  input  logic [CHIP_W-1:0] chip_cnt_i,
  output logic              wr_req_o,
  output logic [47:0]       wr_cfg_o,
  input  logic              wr_ack_i,
  input  logic              wr_ok_i,
  output logic              rd_req_o,
  output logic [CHIP_W-1:0] rd_chip_o,
  input  logic              rd_ack_i,
  input  logic              rd_ok_i,
  input  logic              rd_lock_i,
  input  logic [15:0]       rd_cfg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned NUM_W  = FREQ_W + PRE_SHIFT;
  localparam int unsigned POLL_W = $clog2(MAX_POLLS + 1);

  seq_state_e        state_q;
  logic [CHIP_W-1:0] cnt_q, chip_q;
  logic [POLL_W-1:0] polls_q;
  logic [15:0]       cfg_q;
  logic              done_q, err_q;

  logic              div_start, div_done;
  logic [NUM_W-1:0]  quo;
  logic              norm_done, norm_ok;
  logic [8:0]        norm_fb;
  logic [4:0]        norm_post;
  logic              gap_load, gap_expire;
  logic              locked, match, last_chip, last_poll;

  assign div_start = (state_q == ST_IDLE) && start_i;

  pll_udiv #(.NUM_W(NUM_W), .DEN_W(FREQ_W)) u_div (
    .clk_i, .rst_ni,
    .start_i (div_start),
    .num_i   (NUM_W'(sys_khz_i) << PRE_SHIFT),
    .den_i   (ref_khz_i),
    .done_o  (div_done),
    .quo_o   (quo)
  );

  pll_div_norm #(.FB_W(NUM_W)) u_norm (
    .clk_i, .rst_ni,
    .start_i (div_done),
    .fb_i    (quo),
    .done_o  (norm_done),
    .ok_o    (norm_ok),
    .fb_o    (norm_fb),
    .post_o  (norm_post)
  );

  assign locked    = rd_ok_i && rd_lock_i;
  assign match     = rd_cfg_i == cfg_q;
  assign last_chip = chip_q == cnt_q;
  assign last_poll = polls_q == POLL_W'(MAX_POLLS - 1);
  assign gap_load  = (state_q == ST_READ) && rd_ack_i && !locked && !last_poll;

  pll_gap_timer #(.GAP_CYC(POLL_GAP_CYC)) u_gap (
    .clk_i, .rst_ni,
    .load_i   (gap_load),
    .expire_o (gap_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      chip_q  <= '0;
      polls_q <= '0;
      cfg_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cnt_q   <= chip_cnt_i;
          state_q <= ST_DIV;
        end
        ST_DIV: if (div_done) state_q <= ST_NORM;
        ST_NORM: if (norm_done) begin
          if (norm_ok) begin
            cfg_q   <= {norm_fb[7:0], 2'(PRE_DIV), norm_post, norm_fb[8]};
            state_q <= ST_WRITE;
          end else begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WRITE: if (wr_ack_i) begin
          if (!wr_ok_i) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (cnt_q == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            chip_q  <= CHIP_W'(1);
            polls_q <= '0;
            state_q <= ST_READ;
          end
        end
        ST_READ: if (rd_ack_i) begin
          if (locked) begin
            if (!match) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else if (last_chip) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              chip_q  <= chip_q + 1'b1;
              polls_q <= '0;
            end
          end else if (last_poll) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            polls_q <= polls_q + 1'b1;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: if (gap_expire) state_q <= ST_READ;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_req_o  = state_q == ST_WRITE;
  assign wr_cfg_o  = {16'h0000, CFG_BYTE3, CFG_BYTE2, cfg_q};
  assign rd_req_o  = state_q == ST_READ;
  assign rd_chip_o = chip_q;
  assign busy_o    = state_q != ST_IDLE;
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/pll_cfg_sequencer_chk.sv
module pll_cfg_sequencer_chk #(
  parameter int unsigned CHIP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              wr_req_o,
  input logic              wr_ack_i,
  input logic [47:0]       wr_cfg_o,
  input logic              rd_req_o,
  input logic              rd_ack_i,
  input logic [CHIP_W-1:0] rd_chip_o
);
  assert_end_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  assert_end_on_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> (!busy_o && $past(busy_o)));
  assert_fall_has_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || err_o));
  assert_wr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_cfg_o)));
  assert_req_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_req_o && rd_req_o));
  assert_cfg_fixed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (wr_cfg_o[47:16] == 32'h0000_8421 && wr_cfg_o[7:6] == 2'b10));
  assert_rd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_chip_o)));
  assert_rd_chip_nz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_chip_o != '0));
endmodule

bind pll_cfg_sequencer pll_cfg_sequencer_chk #(.CHIP_W(CHIP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .wr_req_o (wr_req_o),
  .wr_ack_i (wr_ack_i),
  .wr_cfg_o (wr_cfg_o),
  .rd_req_o (rd_req_o),
  .rd_ack_i (rd_ack_i),
  .rd_chip_o(rd_chip_o)
);

// File: tb/tb_pll_cfg_sequencer.sv
`timescale 1ns/1ps
module tb_pll_cfg_sequencer;
  localparam int FW = 12;
  localparam int CW = 4;
  localparam int POLLS = 6;
  localparam int GAP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [FW-1:0] ref_khz = '0, sys_khz = '0;
  logic [CW-1:0] chip_cnt = '0;
  logic wr_ack = 1'b0, wr_ok = 1'b0;
  logic rd_ack = 1'b0, rd_ok = 1'b0, rd_lock = 1'b0;
  logic [15:0] rd_cfg = '0;
  logic wr_req, rd_req, busy, done, err;
  logic [47:0] wr_cfg;
  logic [CW-1:0] rd_chip;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pll_cfg_sequencer #(.FREQ_W(FW), .CHIP_W(CW), .MAX_POLLS(POLLS), .POLL_GAP_CYC(GAP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ref_khz_i(ref_khz), .sys_khz_i(sys_khz), .chip_cnt_i(chip_cnt),
    .wr_req_o(wr_req), .wr_cfg_o(wr_cfg), .wr_ack_i(wr_ack), .wr_ok_i(wr_ok),
    .rd_req_o(rd_req), .rd_chip_o(rd_chip), .rd_ack_i(rd_ack), .rd_ok_i(rd_ok),
    .rd_lock_i(rd_lock), .rd_cfg_i(rd_cfg),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // arithmetic model of the divider choice
  task automatic model(input int r, input int s, output bit e,
                       output logic [7:0] b0, output logic [7:0] b1);
    int fb, post;
    fb = (r == 0) ? (1 << (FW + 3)) - 1 : (s * 8) / r;
    post = 4;
    while (fb > 511 && post <= 16) begin
      fb = fb >> 1;
      post = post << 1;
    end
    e  = post > 16;
    b0 = 8'(128 | ((post & 31) << 1) | ((fb >> 8) & 1));
    b1 = 8'(fb & 255);
  endtask

  task automatic run_seq(input int r, input int s, input int n, input int lock_delay,
                         input int mism_chip, input int dead_chip, input bit wr_fail,
                         input bit poke);
    bit e, fin;
    logic [7:0] b0, b1;
    logic [47:0] saved;
    int t;
    model(r, s, e, b0, b1);
    ref_khz = FW'(r); sys_khz = FW'(s); chip_cnt = CW'(n);
    start = 1'b1; tick(); start = 1'b0;
    t = 0;
    while (!wr_req && !err && !done && t < 100) begin tick(); t++; end
    if (e) begin
      chk(err && !wr_req && !rd_req && !busy, "R3", "post overflow error", {err, wr_req, rd_req, busy}, 4'b1000);
      tick();
      chk(!err && !busy && !wr_req, "R9", "error pulse ends", {err, busy, wr_req}, 3'b000);
      return;
    end
    chk(wr_req && !err && !done, "R1", "write requested", {wr_req, err, done}, 3'b100);
    chk(wr_cfg[7:0] == b0, "R2", "byte0 post/fb8", wr_cfg[7:0], b0);
    chk(wr_cfg[15:8] == b1, "R1", "byte1 fb low", wr_cfg[15:8], b1);
    chk(wr_cfg[47:16] == 32'h0000_8421, "R4", "fixed bytes", wr_cfg[47:16], 32'h0000_8421);
    saved = wr_cfg;
    if (poke) begin
      ref_khz = FW'(r + 1); sys_khz = FW'(s + 5); chip_cnt = '0;
      start = 1'b1; tick(); start = 1'b0;
      chk(wr_req && wr_cfg == saved, "R9", "start while busy ignored", wr_cfg, saved);
    end
    tick();
    chk(wr_req && wr_cfg == saved, "R5", "write held", wr_cfg, saved);
    wr_ack = 1'b1; wr_ok = !wr_fail; tick(); wr_ack = 1'b0; wr_ok = 1'b0;
    if (wr_fail) begin
      chk(err && !rd_req && !done, "R5", "write failure aborts", {err, rd_req, done}, 3'b100);
      tick();
      chk(!err && !rd_req && !busy, "R9", "pulse single", {err, rd_req, busy}, 3'b000);
      return;
    end
    if (n == 0) begin
      chk(done && !rd_req && !busy, "R6", "zero chips done", {done, rd_req, busy}, 3'b100);
      tick();
      chk(!done && !busy, "R9", "done single", {done, busy}, 2'b00);
      return;
    end
    fin = 1'b0;
    for (int c = 1; c <= n; c++) begin
      int att;
      bit next;
      att = 0; next = 1'b0;
      if (fin) break;
      while (!fin && !next) begin
        bit lk;
        int w;
        w = 0;
        while (!rd_req && w < GAP + 20) begin tick(); w++; end
        chk(rd_req && rd_chip == CW'(c), "R6", "chip order", rd_chip, c);
        if (att == 0) chk(w == 0, "R6", "read follows at once", w, 0);
        else chk(w == GAP, "R7", "retry spacing", w, GAP);
        tick();
        chk(rd_req && rd_chip == CW'(c), "R10", "read held", {rd_req, rd_chip}, {1'b1, CW'(c)});
        lk = (c != dead_chip) && (att >= lock_delay);
        rd_ok   = lk ? 1'b1 : att[0];
        rd_lock = lk ? 1'b1 : !att[0];
        rd_cfg  = {(c == mism_chip) ? b1 ^ 8'h01 : b1, b0};
        rd_ack = 1'b1; tick(); rd_ack = 1'b0; rd_ok = 1'b0; rd_lock = 1'b0;
        if (lk) begin
          if (c == mism_chip) begin
            chk(err && !done && !rd_req, "R8", "readback mismatch aborts", {err, done, rd_req}, 3'b100);
            fin = 1'b1;
          end else if (c == n) begin
            chk(done && !err && !rd_req, "R6", "all chips locked", {done, err, rd_req}, 3'b100);
            fin = 1'b1;
          end else begin
            next = 1'b1;
          end
        end else begin
          att++;
          if (att == POLLS) begin
            chk(err && !done && !rd_req, "R7", "poll limit error", {err, done, rd_req}, 3'b100);
            fin = 1'b1;
          end else begin
            chk(!rd_req && busy && !err, "R7", "waiting between polls", {rd_req, busy, err}, 3'b010);
          end
        end
      end
    end
    tick();
    chk(!done && !err && !busy && !rd_req, "R9", "end pulse single", {done, err, busy, rd_req}, 4'b0000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk(!busy && !wr_req && !rd_req && !done && !err, "R9", "reset state",
        {busy, wr_req, rd_req, done, err}, 5'b00000);
    rst_n = 1'b1;
    tick();
    // sweep of divider inputs, no chips
    for (int r = 0; r <= 40; r++) begin
      for (int s = 1; s <= 4095; s += 97) run_seq(r, s, 0, 0, 0, 0, 1'b0, 1'b0);
      run_seq(r, 4095, 0, 0, 0, 0, 1'b0, 1'b0);
    end
    // post-divider boundary: 16 accepted, 32 rejected
    run_seq(4, 1023, 0, 0, 0, 0, 1'b0, 1'b0);
    run_seq(2, 1023, 0, 0, 0, 0, 1'b0, 1'b0);
    // lock sequences
    run_seq(160, 2500, 3, 0, 0, 0, 1'b0, 1'b0);
    run_seq(16, 250, 4, 3, 0, 0, 1'b0, 1'b1);
    run_seq(100, 3000, 15, POLLS - 1, 0, 0, 1'b0, 1'b0);
    run_seq(7, 900, 3, 1, 0, 2, 1'b0, 1'b0);
    run_seq(9, 1200, 4, 2, 2, 0, 1'b0, 1'b0);
    run_seq(9, 1200, 4, 0, 1, 0, 1'b0, 1'b0);
    run_seq(30, 700, 2, 0, 0, 0, 1'b1, 1'b0);
    run_seq(3, 2000, 1, 0, 0, 0, 1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule